// File: doc/BRIEF.md
# Two-Point Calibrated Threshold Calculator

This block turns a requested supply-monitor trip voltage into the pair of decimal threshold digits that a monitor channel expects. It also reports the voltage that those digits really produce. Two calibration readings describe the channel. Each reading is a coarse digit and a fine digit, taken at a low reference of 1860 mV and a high reference of 2980 mV. Each reading becomes a combined code equal to ten times coarse plus fine. The channel is modelled as a straight line through the two readings, and the target is placed on that line.

A request is a one-cycle `start` pulse with the target in millivolts and the four calibration digits. The block runs two passes through a single shared restoring divider. The first pass finds the rounded code. The second pass finds the achieved voltage as a fixed-point millivolt value with 16 fraction bits. When both passes finish, the results appear together with a one-cycle `done` pulse. Requests that fall outside the usable region finish early with `err` set.

Top module: `vcal_thresh_calc`

## Requirements
- R1: With low code cL = 10*lo_coarse+lo_fine and high code cH = 10*hi_coarse+hi_fine, the block computes the code as cL + (target_mv-1860)*(cH-cL)/1120. Equivalently, the slope is 1120/(cH-cL) mV per step and the intercept is 1860 minus the slope times cL.
- R2: The code is rounded to the nearest integer, and an exact half rounds up. With cL=0 and cH=1, a target of 2419 mV gives code 0 and a target of 2420 mV gives code 1.
- R3: When no error occurs, thr_fine equals the code modulo 10 and thr_coarse equals the code divided by 10.
- R4: ach_mv_q equals (code*slope + intercept) in millivolts, scaled by 2^16 and rounded to the nearest unit, with halves rounding up.
- R5: A target below 1620 mV or above 3400 mV sets err. On any error, thr_coarse, thr_fine and ach_mv_q are all 0.
- R6: If cH is not greater than cL, err is set.
- R7: If the rounded code is below 0 or above 10*2^CW-1 (159 by default), err is set.
- R8: A start pulse is accepted only while busy and done are both low. After that, done is high for exactly one cycle per accepted request. A start that arrives while busy is high has no effect on that request's result.
- R9: err, thr_coarse, thr_fine and ach_mv_q change only on the cycle that done rises, and they hold their values until the next result.
- R10: After reset, busy, done and err are low and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse, taken while idle |
| target_mv | input | MV_W (12) | Requested threshold in mV |
| lo_coarse | input | CW (4) | Coarse digit of the 1860 mV calibration |
| lo_fine | input | 4 | Fine digit of the 1860 mV calibration |
| hi_coarse | input | CW (4) | Coarse digit of the 2980 mV calibration |
| hi_fine | input | 4 | Fine digit of the 2980 mV calibration |
| busy | output | 1 | Divider passes are running |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | The last request was rejected |
| thr_coarse | output | CW (4) | Coarse threshold digit |
| thr_fine | output | 4 | Fine threshold digit |
| ach_mv_q | output | MV_W+FRAC+1 (29) | Achieved voltage in mV, with FRAC fraction bits |

## Verification
The checks assume that every fine calibration digit is in the range 0 to 9, so that a combined code never goes past 10*2^CW-1. They also assume that start is a pulse driven from the testbench side and never a level held across the end of a request. The stimulus takes fine digits only from that range, and it sweeps targets in steps of 20 mV across the supported range and slightly beyond it, plus each range edge. This is done for a set of calibration pairs that cover a normal slope, the steepest and flattest slopes, equal codes, reversed codes, and a code that overflows. Directed cases cover the exact rounding tie and a start issued while busy.

// File: rtl/vcal_pkg.sv
package vcal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV1,
    ST_DIV2,
    ST_DONE
  } vcal_st_e;
endpackage

// File: rtl/vcal_divider.sv
// Restoring divider: one quotient bit per cycle, MSB first.
module vcal_divider #(
  parameter int DVD_W = 39,
  parameter int DVS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] q_q, q_d;
  logic [DVS_W:0]   r_q, r_d;
  logic [DVS_W-1:0] dv_q, dv_d;
  logic [CNT_W-1:0] n_q, n_d;
  logic             done_q, done_d;
  logic [DVS_W:0]   shifted;
  logic [DVS_W+1:0] trial;

  always_comb begin
    q_d     = q_q;
    r_d     = r_q;
    dv_d    = dv_q;
    n_d     = n_q;
    done_d  = 1'b0;
    shifted = {r_q[DVS_W-1:0], q_q[DVD_W-1]};
    trial   = {1'b0, shifted} - {2'b00, dv_q};
    if (go) begin
      q_d  = dividend;
      r_d  = '0;
      dv_d = divisor;
      n_d  = CNT_W'(DVD_W);
    end else if (n_q != '0) begin
      if (!trial[DVS_W+1]) begin
        r_d = trial[DVS_W:0];
        q_d = {q_q[DVD_W-2:0], 1'b1};
      end else begin
        r_d = shifted;
        q_d = {q_q[DVD_W-2:0], 1'b0};
      end
      n_d    = n_q - 1'b1;
      done_d = (n_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      r_q    <= '0;
      dv_q   <= '0;
      n_q    <= '0;
      done_q <= 1'b0;
    end else begin
      q_q    <= q_d;
      r_q    <= r_d;
      dv_q   <= dv_d;
      n_q    <= n_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign quotient = q_q;
endmodule

// File: rtl/vcal_digit_split.sv
// Splits a small code into its last decimal digit and the rest.
module vcal_digit_split #(
  parameter int CODE_W = 8,
  parameter int CW     = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [CW-1:0]     coarse,
  output logic [3:0]        fine
);
  always_comb begin
    coarse = CW'(code / CODE_W'(10));
    fine   = 4'(code % CODE_W'(10));
  end
endmodule

// File: rtl/vcal_thresh_calc.sv
module vcal_thresh_calc #(
  parameter int MV_W     = 12,
  parameter int CW       = 4,
  parameter int FRAC     = 16,
  parameter int V_LO_MV  = 1860,
  parameter int V_HI_MV  = 2980,
  parameter int Y_MIN_MV = 1620,
  parameter int Y_MAX_MV = 3400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [MV_W-1:0]      target_mv,
  input  logic [CW-1:0]        lo_coarse,
  input  logic [3:0]           lo_fine,
  input  logic [CW-1:0]        hi_coarse,
  input  logic [3:0]           hi_fine,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [CW-1:0]        thr_coarse,
  output logic [3:0]           thr_fine,
  output logic [MV_W+FRAC:0]   ach_mv_q
);
  import vcal_pkg::*;

  localparam int SPAN     = V_HI_MV - V_LO_MV;
  localparam int CODE_MAX = 10 * (2 ** CW) - 1;
  localparam int CODE_W   = $clog2(CODE_MAX + 1);
  localparam int SPAN_W   = $clog2(SPAN + 1);
  localparam int NW       = MV_W + CODE_W + SPAN_W + 2;
  localparam int DVS_W    = (SPAN_W > CODE_W + 1) ? SPAN_W : CODE_W + 1;
  localparam int DVD_A    = MV_W + CODE_W + FRAC + 3;
  localparam int DVD_W    = (DVD_A > NW) ? DVD_A : NW;
  localparam int AW       = MV_W + FRAC + 1;
  localparam logic signed [NW-1:0] SPAN_S = NW'(SPAN);
  localparam logic signed [NW-1:0] HALF_S = NW'(SPAN / 2);
  localparam logic signed [NW-1:0] VLO_S  = NW'(V_LO_MV);

  // reset synchronizer: assert asynchronously, release on clock
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // request decode
  logic [CODE_W:0]        cl_code, ch_code;
  logic signed [NW-1:0]   cl_s, ch_s, dl_s, tg_s, num1, num2;
  logic                   range_bad, slope_bad, neg_bad;

  always_comb begin
    cl_code   = (CODE_W+1)'(lo_coarse) * (CODE_W+1)'(10) + (CODE_W+1)'(lo_fine);
    ch_code   = (CODE_W+1)'(hi_coarse) * (CODE_W+1)'(10) + (CODE_W+1)'(hi_fine);
    cl_s      = NW'($signed({1'b0, cl_code}));
    ch_s      = NW'($signed({1'b0, ch_code}));
    tg_s      = NW'($signed({1'b0, target_mv}));
    dl_s      = ch_s - cl_s;
    num1      = cl_s * SPAN_S + (tg_s - VLO_S) * dl_s + HALF_S;
    range_bad = (target_mv < MV_W'(Y_MIN_MV)) || (target_mv > MV_W'(Y_MAX_MV));
    slope_bad = dl_s[NW-1] || (dl_s == '0);
    neg_bad   = num1[NW-1];
  end

  // state and working registers
  vcal_st_e              st_q, st_d;
  logic signed [NW-1:0]  clo_q, clo_d, dlt_q, dlt_d;
  logic [CODE_W-1:0]     code_q, code_d;
  logic                  res_err_q, res_err_d;
  logic [CW-1:0]         res_co_q, res_co_d;
  logic [3:0]            res_fi_q, res_fi_d;
  logic [AW-1:0]         res_ach_q, res_ach_d;

  logic                  div_go, div_done;
  logic [DVD_W-1:0]      div_dvd, div_q;
  logic [DVS_W-1:0]      div_dvs;
  logic [CW-1:0]         split_co;
  logic [3:0]            split_fi;

  always_comb begin
    st_d      = st_q;
    clo_d     = clo_q;
    dlt_d     = dlt_q;
    code_d    = code_q;
    res_err_d = res_err_q;
    res_co_d  = res_co_q;
    res_fi_d  = res_fi_q;
    res_ach_d = res_ach_q;
    div_go    = 1'b0;
    div_dvd   = '0;
    div_dvs   = '0;
    num2      = (NW'($signed({1'b0, div_q[CODE_W-1:0]})) - clo_q) * SPAN_S + VLO_S * dlt_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        clo_d = cl_s;
        dlt_d = dl_s;
        if (range_bad || slope_bad || neg_bad) begin
          res_err_d = 1'b1;
          res_co_d  = '0;
          res_fi_d  = '0;
          res_ach_d = '0;
          st_d      = ST_DONE;
        end else begin
          div_go  = 1'b1;
          div_dvd = DVD_W'(num1);
          div_dvs = DVS_W'(SPAN);
          st_d    = ST_DIV1;
        end
      end
      ST_DIV1: if (div_done) begin
        if (div_q > DVD_W'(CODE_MAX)) begin
          res_err_d = 1'b1;
          res_co_d  = '0;
          res_fi_d  = '0;
          res_ach_d = '0;
          st_d      = ST_DONE;
        end else begin
          code_d  = div_q[CODE_W-1:0];
          div_go  = 1'b1;
          div_dvd = (DVD_W'(num2) << FRAC) + DVD_W'(dlt_q >>> 1);
          div_dvs = DVS_W'(dlt_q);
          st_d    = ST_DIV2;
        end
      end
      ST_DIV2: if (div_done) begin
        res_err_d = 1'b0;
        res_co_d  = split_co;
        res_fi_d  = split_fi;
        res_ach_d = AW'(div_q);
        st_d      = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q      <= ST_IDLE;
      clo_q     <= '0;
      dlt_q     <= '0;
      code_q    <= '0;
      res_err_q <= 1'b0;
      res_co_q  <= '0;
      res_fi_q  <= '0;
      res_ach_q <= '0;
    end else begin
      st_q      <= st_d;
      clo_q     <= clo_d;
      dlt_q     <= dlt_d;
      code_q    <= code_d;
      res_err_q <= res_err_d;
      res_co_q  <= res_co_d;
      res_fi_q  <= res_fi_d;
      res_ach_q <= res_ach_d;
    end
  end

  vcal_divider #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_sn),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .done     (div_done),
    .quotient (div_q)
  );

  vcal_digit_split #(.CODE_W(CODE_W), .CW(CW)) u_split (
    .code   (code_q),
    .coarse (split_co),
    .fine   (split_fi)
  );

  assign busy       = (st_q == ST_DIV1) || (st_q == ST_DIV2);
  assign done       = (st_q == ST_DONE);
  assign err        = res_err_q;
  assign thr_coarse = res_co_q;
  assign thr_fine   = res_fi_q;
  assign ach_mv_q   = res_ach_q;
endmodule

// File: rtl/vcal_thresh_calc_chk.sv
module vcal_thresh_calc_chk #(
  parameter int MV_W = 12,
  parameter int CW   = 4,
  parameter int FRAC = 16
) (
  input logic               clk,
  input logic               rst_sn,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic [CW-1:0]      thr_coarse,
  input logic [3:0]         thr_fine,
  input logic [MV_W+FRAC:0] ach_mv_q
);
  // R8: strobe lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  // R8: an idle start leads to work or to a result next cycle
  p_start_taken_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (start && !busy && !done) |=> (busy || done));

  // R5: an error leaves all result fields at zero
  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && err) |-> (thr_coarse == '0 && thr_fine == '0 && ach_mv_q == '0));

  // R3: fine digit is decimal
  p_fine_digit_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && !err) |-> (thr_fine <= 4'd9));

  // R9: results move only when the strobe rises
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !$rose(done) |-> $stable({err, thr_coarse, thr_fine, ach_mv_q}));
endmodule

bind vcal_thresh_calc vcal_thresh_calc_chk #(.MV_W(MV_W), .CW(CW), .FRAC(FRAC)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .thr_coarse (thr_coarse),
  .thr_fine   (thr_fine),
  .ach_mv_q   (ach_mv_q)
);

// File: tb/vcal_thresh_calc_tb.sv
module vcal_thresh_calc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [11:0] target_mv;
  logic [3:0]  lo_coarse, lo_fine, hi_coarse, hi_fine;
  logic        busy, done, err;
  logic [3:0]  thr_coarse, thr_fine;
  logic [28:0] ach_mv_q;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcal_thresh_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_mv(target_mv),
    .lo_coarse(lo_coarse), .lo_fine(lo_fine), .hi_coarse(hi_coarse), .hi_fine(hi_fine),
    .busy(busy), .done(done), .err(err), .thr_coarse(thr_coarse), .thr_fine(thr_fine),
    .ach_mv_q(ach_mv_q)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected behaviour from the requirements
  task automatic model(input int lc, lf, hc, hf, y,
                       output bit e_err, output int e_co, output int e_fi,
                       output longint e_ach, output string etag);
    int cl, ch, d;
    longint n, code, m;
    cl = 10*lc + lf; ch = 10*hc + hf; d = ch - cl;
    e_err = 1'b0; e_co = 0; e_fi = 0; e_ach = 0; etag = "R1";
    if (y < 1620 || y > 3400) begin e_err = 1'b1; etag = "R5"; return; end
    if (d <= 0) begin e_err = 1'b1; etag = "R6"; return; end
    n = longint'(cl)*1120 + longint'(y-1860)*d + 560;
    if (n < 0) begin e_err = 1'b1; etag = "R7"; return; end
    code = n / 1120;
    if (code > 159) begin e_err = 1'b1; etag = "R7"; return; end
    m = longint'(1860)*d + (code - cl)*1120;
    e_co  = int'(code / 10);
    e_fi  = int'(code % 10);
    e_ach = ((m <<< 16) + d/2) / d;
  endtask

  task automatic fire(input int lc, lf, hc, hf, y);
    @(negedge clk);
    lo_coarse = 4'(lc); lo_fine = 4'(lf); hi_coarse = 4'(hc); hi_fine = 4'(hf);
    target_mv = 12'(y);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run(input int lc, lf, hc, hf, y, input string tag_over);
    bit e_err, ok;
    int e_co, e_fi;
    longint e_ach;
    string etag, t;
    model(lc, lf, hc, hf, y, e_err, e_co, e_fi, e_ach, etag);
    t = (tag_over != "") ? tag_over : etag;
    fire(lc, lf, hc, hf, y);
    wait_done(ok);
    chk({"R8 done seen ", t}, longint'(ok), 1);
    chk({"err ", t}, longint'(err), longint'(e_err));
    chk({"R3 coarse ", t}, longint'(thr_coarse), longint'(e_co));
    chk({"R3 fine ", t}, longint'(thr_fine), longint'(e_fi));
    chk({"R4 achieved ", t}, longint'(ach_mv_q), e_ach);
    @(negedge clk);
    chk("R8 done one cycle", longint'(done), 0);
  endtask

  int cal [8][4] = '{'{3,5,8,7}, '{0,0,0,1}, '{1,0,15,9}, '{5,0,6,0},
                     '{2,0,2,0}, '{8,7,3,5}, '{0,0,15,9}, '{10,0,15,9}};

  initial begin
    bit ok;
    logic [3:0]  h_co, h_fi;
    logic [28:0] h_ach;
    logic        h_err;
    rst_n = 1'b0; start = 1'b0; target_mv = '0;
    lo_coarse = '0; lo_fine = '0; hi_coarse = '0; hi_fine = '0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 busy", longint'(busy), 0);
    chk("R10 done", longint'(done), 0);
    chk("R10 err", longint'(err), 0);
    chk("R10 coarse", longint'(thr_coarse), 0);
    chk("R10 fine", longint'(thr_fine), 0);
    chk("R10 achieved", longint'(ach_mv_q), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: rounding tie and just below it
    run(0, 0, 0, 1, 2419, "R2");
    run(0, 0, 0, 1, 2420, "R2");
    // R1: reference example, cal codes 35 and 87, target 2200 mV
    run(3, 5, 8, 7, 2200, "R1");

    // R8: start while busy does not change the running request
    fire(3, 5, 8, 7, 2600);
    @(negedge clk);
    chk("R8 busy after start", longint'(busy), 1);
    lo_coarse = 4'd0; lo_fine = 4'd0; hi_coarse = 4'd15; hi_fine = 4'd9; target_mv = 12'd3000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit e_err; int e_co, e_fi; longint e_ach; string etag;
      model(3, 5, 8, 7, 2600, e_err, e_co, e_fi, e_ach, etag);
      wait_done(ok);
      chk("R8 done after ignored start", longint'(ok), 1);
      chk("R8 coarse unaffected", longint'(thr_coarse), longint'(e_co));
      chk("R8 fine unaffected", longint'(thr_fine), longint'(e_fi));
      chk("R8 achieved unaffected", longint'(ach_mv_q), e_ach);
    end
    // R9: results hold while inputs change without start
    h_co = thr_coarse; h_fi = thr_fine; h_ach = ach_mv_q; h_err = err;
    target_mv = 12'd1700; lo_coarse = 4'd1; hi_coarse = 4'd2;
    repeat (6) @(negedge clk);
    chk("R9 coarse held", longint'(thr_coarse), longint'(h_co));
    chk("R9 fine held", longint'(thr_fine), longint'(h_fi));
    chk("R9 achieved held", longint'(ach_mv_q), longint'(h_ach));
    chk("R9 err held", longint'(err), longint'(h_err));

    // sweep: every calibration set against the target range and its edges
    foreach (cal[i]) begin
      for (int y = 1600; y <= 3420; y += 20)
        run(cal[i][0], cal[i][1], cal[i][2], cal[i][3], y, "");
      run(cal[i][0], cal[i][1], cal[i][2], cal[i][3], 1619, "");
      run(cal[i][0], cal[i][1], cal[i][2], cal[i][3], 1620, "");
      run(cal[i][0], cal[i][1], cal[i][2], cal[i][3], 3400, "");
      run(cal[i][0], cal[i][1], cal[i][2], cal[i][3], 3401, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule